// File: doc/BRIEF.md
# Programmable-length SPI transceiver

This block is a serial peripheral transceiver that works either as the bus master or as a selected slave. Software sets a role bit, an enable bit, a 4-bit character-length code and a 4-bit divider code. The block takes these settings at the moment enable rises and keeps them until enable falls. Character length is the code plus one. Codes 3 through 15 give characters of 4 to 16 bits.

In master role, an internal divider turns the baud clock (`clk`) into a serial clock with a 50% duty cycle. The block shifts one character out on MOSI, most significant bit first, and takes one character in from MISO. In slave role, the block synchronises the external clock, data and active-low select into the baud-clock domain. It shifts only while select is low, and drives MISO only while selected.

In both roles the user side exchanges one character at a time through a valid/ready load port. A one-cycle `done` strobe reports each finished exchange. The received character is presented right-aligned in 16 bits.

Top module: `spi_xcvr`

## Requirements
- R1: With the latched role bit at 1 (master), `sck_oe` and `mosi_oe` are high and `miso_oe` stays low. With the role bit at 0 (slave), `miso_oe` is high only while the synchronised `sel_n_i` is low.
- R2: While `cfg_enable` is 0, one clock later `sck_o`, `done`, `tx_ready` and `miso_oe` are all 0. Dropping enable during a character abandons it, and no `done` follows.
- R3: The character length is `cfg_len`+1 bits. Codes 3 to 15 are supported, which gives 4 to 16 bits.
- R4: In master role, each level of `sck_o` lasts 2*(`cfg_pm`+1) cycles of `clk`. The serial clock period is therefore 4*(`cfg_pm`+1) cycles, with equal high and low times.
- R5: In master role the clock idles low. MOSI presents character bit len-1 from the clock edge that accepts the load. MOSI moves to the next lower bit on each falling edge of `sck_o`. MISO is sampled on the `clk` edge at which `sck_o` rises.
- R6: `done` is high for exactly one cycle per finished character. In that cycle `rx_data` holds the received bits right-aligned, first-received bit in position len-1, and bits len to 15 are zero. In master role, `done` comes at the falling edge that follows the last rising edge.
- R7: Role, length and divider are captured in the cycle in which `cfg_enable` rises. Changes to `cfg_master`, `cfg_len` or `cfg_pm` while enabled have no effect.
- R8: `tx_ready` is high when the block is enabled and able to take a character. A character is taken on a cycle with both `tx_valid` and `tx_ready` high. In master role this starts a transfer. In slave role it places bit len-1 on `miso_o` and drops `tx_ready` until that character completes.
- R9: In slave role, `sck_i` edges are ignored while `sel_n_i` is high. While selected, the block samples MOSI on rising edges, advances MISO on falling edges, and raises `done` after the len-th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Baud clock; also the block's only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | Role: 1 master, 0 slave |
| cfg_enable | input | 1 | Enable; 0 holds the block idle |
| cfg_len | input | 4 | Character length minus one |
| cfg_pm | input | 4 | Divider code; serial clock = clk / (4*(code+1)) |
| tx_data | input | 16 | Character to send, right-aligned |
| tx_valid | input | 1 | Load request |
| tx_ready | output | 1 | Block can accept a character |
| rx_data | output | 16 | Last received character, right-aligned |
| done | output | 1 | One-cycle completion strobe |
| sck_o | output | 1 | Serial clock driven in master role |
| sck_oe | output | 1 | Drive enable for sck_o |
| sck_i | input | 1 | Serial clock received in slave role |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Drive enable for miso_o (high-Z when low) |
| miso_i | input | 1 | Master data in |
| sel_n_i | input | 1 | Active-low slave select |

## Verification
In master role, the bench compares `sck_o`, `mosi_o` and `done` against a behavioural timeline on every clock. It does this for the shortest and longest characters and for the smallest and largest dividers. A divider off by one shows up as a mismatched toggle cycle, and a bit-order slip as a wrong MOSI level. The bench changes every setting while enabled to catch a design that reads live mode inputs rather than latched ones. It also drops enable mid-character to expose a design that still strobes `done`. In slave role, the bench toggles the serial clock while deselected and then checks that MISO still shows the first bit. A design that shifts while deselected shows the wrong bit there and also produces a premature strobe.

// File: rtl/spi_pkg.sv
package spi_pkg;

   typedef enum logic {
      ROLE_SLAVE  = 1'b0,
      ROLE_MASTER = 1'b1
   } spi_role_e;

   // Number of baud clocks per serial clock level for a divider code.
   function automatic int unsigned half_cycles(input int unsigned code);
      return 2 * (code + 1);
   endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int          STAGES = 2,
   parameter int          W      = 1,
   parameter logic [W-1:0] INIT  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial assert (STAGES >= 0 && STAGES <= 4)
      else $error("spi_sync: STAGES must be 0..4");

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= INIT;
            end else begin
               st[0] <= d;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
   parameter int PM_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PM_W-1:0] pm,
   output logic            sck,
   output logic            rise,
   output logic            fall
);

   localparam int CW = PM_W + 2;

   logic [CW-1:0] cnt;
   logic [CW-1:0] half_m1;
   logic          wrap;

   assign half_m1 = CW'(spi_pkg::half_cycles(int'(pm)) - 1);
   assign wrap    = (cnt == half_m1);
   assign rise    = run & wrap & ~sck;
   assign fall    = run & wrap & sck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         sck <= ~sck;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R4: the serial clock never changes while the divider is stopped
   a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sck);

endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
   parameter int DW = 16,
   parameter int LW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [DW-1:0] ld_data,
   input  logic          smp,
   input  logic          shf,
   input  logic          restart,
   input  logic          abort,
   input  logic          din,
   input  logic [LW-1:0] lenm1,
   output logic          dout,
   output logic [DW-1:0] rx_word,
   output logic [DW-1:0] rx_next,
   output logic          n_zero,
   output logic          n_last,
   output logic          n_full
);

   logic [DW-1:0] tx_sr;
   logic [DW-1:0] rx_sr;
   logic [LW:0]   nsamp;
   logic [LW:0]   len_ext;

   assign len_ext = {1'b0, lenm1};
   assign dout    = tx_sr[lenm1];
   assign rx_word = rx_sr;
   assign rx_next = {rx_sr[DW-2:0], din};
   assign n_zero  = (nsamp == '0);
   assign n_last  = (nsamp == len_ext);
   assign n_full  = (nsamp == len_ext + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr <= '0;
         rx_sr <= '0;
         nsamp <= '0;
      end else if (clr) begin
         tx_sr <= '0;
         rx_sr <= '0;
         nsamp <= '0;
      end else if (load) begin
         tx_sr <= ld_data;
         rx_sr <= '0;
         nsamp <= '0;
      end else if (restart) begin
         tx_sr <= '0;
         rx_sr <= '0;
         nsamp <= '0;
      end else if (abort) begin
         rx_sr <= '0;
         nsamp <= '0;
      end else begin
         if (smp) begin
            rx_sr <= rx_next;
            nsamp <= nsamp + 1'b1;
         end
         if (shf) tx_sr <= tx_sr << 1;
      end
   end

   // R3: never more samples than the character length
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      nsamp <= len_ext + 1'b1);

endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr #(
   parameter int DATA_W      = 16,
   parameter int LEN_W       = 4,
   parameter int PM_W        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_master,
   input  logic              cfg_enable,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [PM_W-1:0]   cfg_pm,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [DATA_W-1:0] rx_data,
   output logic              done,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              sck_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              miso_i,
   input  logic              sel_n_i
);
   import spi_pkg::*;

   initial assert (DATA_W == (1 << LEN_W))
      else $error("spi_xcvr: DATA_W must equal 2**LEN_W");

   // latched configuration (R7)
   logic             en_q;
   spi_role_e        role_l;
   logic [LEN_W-1:0] len_l;
   logic [PM_W-1:0]  pm_l;
   logic             is_m;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         role_l <= ROLE_SLAVE;
         len_l  <= '0;
         pm_l   <= '0;
      end else begin
         en_q <= cfg_enable;
         if (cfg_enable && !en_q) begin
            role_l <= spi_role_e'(cfg_master);
            len_l  <= cfg_len;
            pm_l   <= cfg_pm;
         end
      end
   end
   assign is_m = (role_l == ROLE_MASTER);

   // slave-side pin synchronisers
   logic [2:0] pins_s;
   logic       sck_s, mosi_s, sel_act, sck_d;

   spi_sync #(.STAGES(SYNC_STAGES), .W(3), .INIT(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({sel_n_i, sck_i, mosi_i}), .q(pins_s));

   assign sel_act = ~pins_s[2];
   assign sck_s   = pins_s[1];
   assign mosi_s  = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   // shared engine wiring
   logic              busy_m, loaded_s, acc;
   logic              rise_m, fall_m, sck_m;
   logic              rise_s, fall_s, s_active;
   logic              m_fin, s_fin;
   logic              smp, shf, din, dout;
   logic              n_zero, n_last, n_full;
   logic [DATA_W-1:0] rx_word, rx_next;

   spi_clkgen #(.PM_W(PM_W)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(busy_m & cfg_enable), .pm(pm_l),
      .sck(sck_m), .rise(rise_m), .fall(fall_m));

   assign s_active = en_q & ~is_m & sel_act;
   assign rise_s   = s_active & sck_s & ~sck_d;
   assign fall_s   = s_active & ~sck_s & sck_d & ~n_zero;
   assign m_fin    = fall_m & n_full;
   assign s_fin    = rise_s & n_last;

   assign smp = is_m ? rise_m : rise_s;
   assign shf = is_m ? (fall_m & ~n_full) : fall_s;
   assign din = is_m ? miso_i : mosi_s;

   spi_shift #(.DW(DATA_W), .LW(LEN_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr(~cfg_enable), .load(acc),
      .ld_data(tx_data), .smp(smp), .shf(shf), .restart(s_fin),
      .abort(en_q & ~is_m & ~sel_act), .din(din), .lenm1(len_l),
      .dout(dout), .rx_word(rx_word), .rx_next(rx_next),
      .n_zero(n_zero), .n_last(n_last), .n_full(n_full));

   assign tx_ready = en_q & (is_m ? ~busy_m : (~loaded_s & n_zero));
   assign acc      = tx_valid & tx_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_m   <= 1'b0;
         loaded_s <= 1'b0;
         done     <= 1'b0;
         rx_data  <= '0;
      end else if (!cfg_enable) begin
         busy_m   <= 1'b0;
         loaded_s <= 1'b0;
         done     <= 1'b0;
         rx_data  <= '0;
      end else begin
         done <= m_fin | s_fin;
         if (acc && is_m)  busy_m <= 1'b1;
         else if (m_fin)   busy_m <= 1'b0;
         if (acc && !is_m) loaded_s <= 1'b1;
         else if (s_fin)   loaded_s <= 1'b0;
         if (m_fin)        rx_data <= rx_word;
         else if (s_fin)   rx_data <= rx_next;
      end
   end

   assign sck_o   = sck_m;
   assign sck_oe  = en_q & is_m;
   assign mosi_o  = is_m & dout;
   assign mosi_oe = en_q & is_m;
   assign miso_o  = ~is_m & dout;
   assign miso_oe = s_active;

   // observation of serial clock level lengths for R4
   logic       sck_prev, busy_prev;
   logic [7:0] since;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev  <= 1'b0;
         busy_prev <= 1'b0;
         since     <= '0;
      end else begin
         sck_prev  <= sck_o;
         busy_prev <= busy_m;
         if (acc)                    since <= 8'd0;
         else if (sck_o != sck_prev) since <= 8'd1;
         else                        since <= since + 8'd1;
      end
   end

   a_r4_level_length: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_m && busy_prev && sck_o != sck_prev)
         |-> (since == 8'(half_cycles(int'(pm_l)))));

   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> (!sck_o && !done && !tx_ready && !miso_oe));

   a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && $past(en_q)) |-> ($stable(len_l) && $stable(pm_l) && $stable(role_l)));

   a_r3_len_min: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_enable && !en_q) |-> (cfg_len >= LEN_W'(3)));

   a_r1_role_drive: assert property (@(posedge clk) disable iff (!rst_n)
      sck_oe |-> !miso_oe);

endmodule

// File: tb/spi_xcvr_bench.sv
module spi_xcvr_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_master = 1'b0, cfg_enable = 1'b0;
   logic [3:0]  cfg_len = 4'd7, cfg_pm = 4'd0;
   logic [15:0] tx_data = '0;
   logic        tx_valid = 1'b0;
   logic        tx_ready, done, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
   logic [15:0] rx_data;
   logic        sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, sel_n_i = 1'b1;

   int checks = 0;
   int errors = 0;
   int done_seen = 0;
   logic [15:0] last_rx = '0;

   always #5 clk = ~clk;

   spi_xcvr u_spi_xcvr (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_enable(cfg_enable),
      .cfg_len(cfg_len), .cfg_pm(cfg_pm), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_data(rx_data), .done(done), .sck_o(sck_o),
      .sck_oe(sck_oe), .sck_i(sck_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
      .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i),
      .sel_n_i(sel_n_i));

   always @(negedge clk) begin
      if (done === 1'b1) begin
         done_seen++;
         last_rx = rx_data;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic setup(input logic m, input int len, input int pm);
      @(negedge clk);
      cfg_enable = 1'b0;
      @(negedge clk);
      cfg_master = m;
      cfg_len    = 4'(len - 1);
      cfg_pm     = 4'(pm);
      cfg_enable = 1'b1;
      @(negedge clk);
   endtask

   // master timeline model: t counts clk edges since the accepting edge
   task automatic m_xfer(input logic [15:0] tx, input logic [15:0] pat,
                         input int len, input int pm);
      int h, end_t, b;
      logic [31:0] mask;
      h     = 2 * (pm + 1);
      end_t = 2 * h * len;
      mask  = (32'd1 << len) - 1;
      @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = tx;
      check("R8 ready before load", {31'd0, tx_ready}, 32'd1);
      miso_i = pat[len-1];
      for (int t = 0; t <= end_t; t++) begin
         @(negedge clk);
         tx_valid = 1'b0;
         tx_data  = 16'hFFFF;
         check("R4 sck level", {31'd0, sck_o}, (t / h) % 2);
         check("R6 done timing", {31'd0, done}, {31'd0, t == end_t});
         if (t < end_t) begin
            b = t / (2 * h);
            check("R5 mosi bit", {31'd0, mosi_o}, {31'd0, tx[len-1-b]});
            miso_i = pat[len-1-b];
         end else begin
            check("R6 rx right-aligned", {16'd0, rx_data}, {16'd0, pat} & mask);
         end
      end
      @(negedge clk);
      check("R6 done single cycle", {31'd0, done}, 32'd0);
      check("R8 ready after done", {31'd0, tx_ready}, 32'd1);
   endtask

   task automatic s_xfer(input logic [15:0] tx, input logic [15:0] pat, input int len);
      int base;
      logic [31:0] mask;
      mask = (32'd1 << len) - 1;
      sel_n_i = 1'b1;
      sck_i   = 1'b0;
      repeat (4) @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = tx;
      check("R8 slave ready", {31'd0, tx_ready}, 32'd1);
      @(negedge clk);
      tx_valid = 1'b0;
      check("R8 slave loaded", {31'd0, tx_ready}, 32'd0);
      check("R1 miso hiZ deselected", {31'd0, miso_oe}, 32'd0);
      base = done_seen;
      for (int k = 0; k < 3; k++) begin
         sck_i = 1'b1; repeat (6) @(negedge clk);
         sck_i = 1'b0; repeat (6) @(negedge clk);
      end
      check("R9 no shift deselected", {31'd0, miso_o}, {31'd0, tx[len-1]});
      check("R9 no done deselected", done_seen, base);
      sel_n_i = 1'b0;
      repeat (6) @(negedge clk);
      check("R1 miso driven selected", {31'd0, miso_oe}, 32'd1);
      for (int k = 0; k < len; k++) begin
         mosi_i = pat[len-1-k];
         repeat (6) @(negedge clk);
         check("R9 miso bit", {31'd0, miso_o}, {31'd0, tx[len-1-k]});
         sck_i = 1'b1; repeat (6) @(negedge clk);
         sck_i = 1'b0; repeat (6) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      check("R6 slave one done", done_seen, base + 1);
      check("R9 slave rx", {16'd0, last_rx}, {16'd0, pat} & mask);
      sel_n_i = 1'b1;
      repeat (6) @(negedge clk);
      check("R1 miso released", {31'd0, miso_oe}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 reset sck", {31'd0, sck_o}, 32'd0);
      check("R2 reset done", {31'd0, done}, 32'd0);
      check("R2 reset ready", {31'd0, tx_ready}, 32'd0);
      check("R2 reset miso_oe", {31'd0, miso_oe}, 32'd0);

      setup(1'b1, 8, 0);
      check("R1 master drives sck", {31'd0, sck_oe}, 32'd1);
      check("R1 master drives mosi", {31'd0, mosi_oe}, 32'd1);
      check("R1 master miso off", {31'd0, miso_oe}, 32'd0);
      m_xfer(16'h00A5, 16'h003C, 8, 0);

      setup(1'b1, 16, 2);
      // R7: settings changed while enabled must be ignored
      cfg_pm = 4'd5; cfg_len = 4'd7; cfg_master = 1'b0;
      m_xfer(16'hBEEF, 16'h1234, 16, 2);

      setup(1'b1, 4, 15);
      m_xfer(16'hFFF9, 16'h0006, 4, 15);

      setup(1'b1, 13, 1);
      m_xfer(16'h1A5C, 16'h0F0F, 13, 1);

      // R2: disable in the middle of a character
      @(negedge clk);
      tx_valid = 1'b1; tx_data = 16'h1234;
      @(negedge clk);
      tx_valid = 1'b0;
      repeat (10) @(negedge clk);
      base = done_seen;
      cfg_enable = 1'b0;
      @(negedge clk);
      check("R2 sck low when off", {31'd0, sck_o}, 32'd0);
      check("R2 ready low when off", {31'd0, tx_ready}, 32'd0);
      repeat (80) @(negedge clk);
      check("R2 no done after abandon", done_seen, base);

      setup(1'b0, 8, 0);
      s_xfer(16'h00C3, 16'h005A, 8);
      setup(1'b0, 12, 0);
      s_xfer(16'h0ABC, 16'h035E, 12);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule